// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Front End

This block is the receiving front end of a two-wire (I2C) slave. It brings the clock and data lines into the system clock domain, recognises START and STOP conditions, and shifts in the first byte after each START. From that byte it decides whether this device is being addressed. If it is, the block pulls the data line low during the ninth clock and raises one of three target selects: a memory array, a control/status register or a potentiometer bank.

The block then holds a read/write flag and a transaction-active level until the next STOP or START. Everything after the address byte belongs to downstream logic, which takes over once `txn_active` rises. An external write-enable latch level decides whether a write to one of the two protected targets is accepted. A write that the latch refuses is answered with no acknowledge and a single-cycle status pulse.

Top module: `twi_addr_front`

## Requirements
- R1: After reset every output is low: `ack_drive_low`, `target_sel`, `rd_flag`, `txn_active` and `wr_reject`.
- R2: START is the data line falling while the clock line is high. STOP is the data line rising while the clock line is high. A STOP in any state returns the block to idle, and one clock edge later all selects, `txn_active`, `rd_flag` and `ack_drive_low` are low.
- R3: The address byte is sampled most significant bit first, on rising clock-line edges. The device answers only if bits 7:4 equal binary 1010.
- R4: Bit 3 of the address byte must equal the `phys_addr` pin, or the byte is not acknowledged.
- R5: Bits 2:1 pick the target, and `target_sel` is one-hot with at most one bit set. Code 00 sets bit 0 (memory), code 10 sets bit 1 (control/status) and code 11 sets bit 2 (potentiometers). Code 01 is reserved: it is never acknowledged, sets no select and raises no reject pulse.
- R6: `rd_flag` equals bit 0 of an accepted address byte (1 = read, 0 = write). It is low when no target is selected.
- R7: A write (bit 0 = 0) to the memory or potentiometer target is accepted only when `wel` is high at the clock-line falling edge after bit 8. Otherwise the byte is not acknowledged and `wr_reject` pulses high for exactly one cycle. Writes to the control/status target do not depend on `wel`.
- R8: `ack_drive_low` rises only at the clock-line falling edge after bit 8 of an accepted byte. It falls at the following clock-line falling edge, after bit 9, and is never high at any other time.
- R9: `txn_active` and the select rise together with the acknowledge. Both stay high until STOP or START. After a byte that is not acknowledged, further clock pulses are ignored until the next START.
- R10: A repeated START in any state clears the selects and restarts capture of a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| phys_addr | input | 1 | Strap level that address bit 3 must match |
| wel | input | 1 | Write-enable latch level |
| ack_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| target_sel | output | 3 | One-hot select: bit 0 memory, bit 1 control/status, bit 2 potentiometers |
| rd_flag | output | 1 | Read requested by the accepted byte |
| txn_active | output | 1 | Device addressed and transaction in progress |
| wr_reject | output | 1 | One-cycle pulse when a protected write is refused |

## Verification
The hardest situation to reach from the ports is the acknowledge window. There the block's own drive feeds back through the wired bus onto `sda_in`, and a wrong edge would show up as a false START or STOP. The bench models the wired-AND of the master and the slave drive and walks the clock through the ninth pulse with the master released. A repeated START is issued while a target is still selected, and a STOP is issued in the middle of an address byte. These check that both conditions cut the capture off cleanly and that the next full byte is decoded from a fresh count.

// File: rtl/twi_af_pkg.sv
package twi_af_pkg;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;
    localparam int         NUM_TGT    = 3;

    typedef enum logic [1:0] {
        TGT_MEM  = 2'b00,
        TGT_RSVD = 2'b01,
        TGT_CTL  = 2'b10,
        TGT_POT  = 2'b11
    } tgt_code_e;

    typedef struct packed {
        logic [3:0] family;
        logic       strap;
        tgt_code_e  tgt;
        logic       rnw;
    } addr_byte_t;

    localparam int ADDR_W = $bits(addr_byte_t);
    localparam int CNT_W  = $clog2(ADDR_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_ACK,
        PH_SELECTED,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic [NUM_TGT-1:0] tgt_onehot(input tgt_code_e c);
        case (c)
            TGT_MEM: return 3'b001;
            TGT_CTL: return 3'b010;
            TGT_POT: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic tgt_guarded(input tgt_code_e c);
        return (c == TGT_MEM) || (c == TGT_POT);
    endfunction

endpackage

// File: rtl/twi_af_sync.sv
module twi_af_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else if (s == 0) chain[s] <= async_in;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/twi_af_cond.sv
module twi_af_cond
    import twi_af_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
        evt.rise  = scl_s & ~scl_q;
        evt.fall  = ~scl_s & scl_q;
        evt.sda   = sda_s;
    end

    a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.stop));
endmodule

// File: rtl/twi_af_ctrl.sv
module twi_af_ctrl
    import twi_af_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic               phys_addr,
    input  logic               wel,
    output logic               ack_drive_low,
    output logic [NUM_TGT-1:0] target_sel,
    output logic               rd_flag,
    output logic               txn_active,
    output logic               wr_reject
);
    phase_e            phase;
    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    addr_byte_t ab;
    logic id_ok, strap_ok, tgt_ok, wr_blocked, accept, refuse;

    always_comb begin
        ab         = addr_byte_t'(shreg);
        id_ok      = (ab.family == DEV_FAMILY);
        strap_ok   = (ab.strap == phys_addr);
        tgt_ok     = (ab.tgt != TGT_RSVD);
        wr_blocked = ~ab.rnw & tgt_guarded(ab.tgt) & ~wel;
        accept     = id_ok & strap_ok & tgt_ok & ~wr_blocked;
        refuse     = id_ok & strap_ok & tgt_ok & wr_blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_IDLE;
            shreg         <= '0;
            cnt           <= '0;
            ack_drive_low <= 1'b0;
            target_sel    <= '0;
            rd_flag       <= 1'b0;
            txn_active    <= 1'b0;
            wr_reject     <= 1'b0;
        end else begin
            wr_reject <= 1'b0;
            if (evt.stop || evt.start) begin
                phase         <= evt.stop ? PH_IDLE : PH_SHIFT;
                cnt           <= '0;
                ack_drive_low <= 1'b0;
                target_sel    <= '0;
                rd_flag       <= 1'b0;
                txn_active    <= 1'b0;
            end else begin
                case (phase)
                    PH_SHIFT: begin
                        if (evt.rise && cnt != CNT_W'(ADDR_W)) begin
                            shreg <= {shreg[ADDR_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.fall && cnt == CNT_W'(ADDR_W)) begin
                            if (accept) begin
                                phase         <= PH_ACK;
                                ack_drive_low <= 1'b1;
                                target_sel    <= tgt_onehot(ab.tgt);
                                rd_flag       <= ab.rnw;
                                txn_active    <= 1'b1;
                            end else begin
                                phase <= PH_IGNORE;
                            end
                            wr_reject <= refuse;
                        end
                    end
                    PH_ACK: begin
                        if (evt.fall) begin
                            phase         <= PH_SELECTED;
                            ack_drive_low <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: at most one target is ever selected
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(target_sel));
    // R9: active flag and a select travel together
    a_r9_active_has_sel: assert property (@(posedge clk) disable iff (rst)
        txn_active |-> $onehot(target_sel));
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (!txn_active && target_sel == '0 && !ack_drive_low));
    a_r7_reject_no_ack: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> (!ack_drive_low && !txn_active));
    a_r7_reject_single: assert property (@(posedge clk) disable iff (rst)
        wr_reject |=> !wr_reject);
    a_r8_ack_rises_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_drive_low) |-> $past(evt.fall));
    a_r8_ack_needs_active: assert property (@(posedge clk) disable iff (rst)
        ack_drive_low |-> txn_active);
endmodule

// File: rtl/twi_addr_front.sv
module twi_addr_front
    import twi_af_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               phys_addr,
    input  logic               wel,
    output logic               ack_drive_low,
    output logic [NUM_TGT-1:0] target_sel,
    output logic               rd_flag,
    output logic               txn_active,
    output logic               wr_reject
);
    logic [1:0] lines_s;
    bus_evt_t   evt;

    twi_af_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({scl_in, sda_in}),
        .sync_out (lines_s)
    );

    twi_af_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt   (evt)
    );

    twi_af_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .evt           (evt),
        .phys_addr     (phys_addr),
        .wel           (wel),
        .ack_drive_low (ack_drive_low),
        .target_sel    (target_sel),
        .rd_flag       (rd_flag),
        .txn_active    (txn_active),
        .wr_reject     (wr_reject)
    );
endmodule

// File: tb/twi_addr_front_test.sv
module twi_addr_front_test;
    localparam int SETTLE = 5;
    localparam int HOLD   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic phys_addr = 1'b0, wel = 1'b0;
    logic ack_drive_low, rd_flag, txn_active, wr_reject;
    logic [2:0] target_sel;
    logic sda_bus;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~ack_drive_low;

    twi_addr_front uut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
        .phys_addr(phys_addr), .wel(wel),
        .ack_drive_low(ack_drive_low), .target_sel(target_sel),
        .rd_flag(rd_flag), .txn_active(txn_active), .wr_reject(wr_reject)
    );

    // behavioural reference model state
    int   m_mode = 0;       // 0 idle, 1 shifting, 2 acking, 3 selected, 4 ignoring
    int   m_bits = 0;
    int   m_byte = 0;
    logic e_oe = 0, e_rd = 0, e_act = 0;
    logic [2:0] e_sel = 0;
    int   e_rej = 0, seen_rej = 0;
    logic chk_en = 0;
    string tag = "R1";
    int vectors = 0, errors = 0, cyc = 0;
    bit done = 0;

    task automatic report;
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    task automatic check(input string req, input int got, input int exp, input string what);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && wr_reject) seen_rej++;
        if (chk_en && !rst) begin
            vectors++;
            if (ack_drive_low !== e_oe || target_sel !== e_sel || rd_flag !== e_rd ||
                txn_active !== e_act || wr_reject !== 1'b0) begin
                errors++;
                $display("FAIL %s per-clock: got oe=%b sel=%b rd=%b act=%b rej=%b expected oe=%b sel=%b rd=%b act=%b rej=0",
                         tag, ack_drive_low, target_sel, rd_flag, txn_active, wr_reject,
                         e_oe, e_sel, e_rd, e_act);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired: got %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic model(input logic os, input logic ol, input logic ns, input logic nl);
        if (os && ns && ol && !nl) begin
            m_mode = 1; m_bits = 0; m_byte = 0;
            e_oe = 0; e_sel = 0; e_rd = 0; e_act = 0;
        end else if (os && ns && !ol && nl) begin
            m_mode = 0; e_oe = 0; e_sel = 0; e_rd = 0; e_act = 0;
        end else if (!os && ns) begin
            if (m_mode == 1 && m_bits < 8) begin
                m_byte = (m_byte * 2 + int'(nl)) % 256;
                m_bits++;
            end
        end else if (os && !ns) begin
            if (m_mode == 1 && m_bits == 8) begin
                int fam   = m_byte / 16;
                int strap = (m_byte / 8) % 2;
                int code  = (m_byte / 2) % 4;
                int rd    = m_byte % 2;
                bit hit   = (fam == 10) && (strap == int'(phys_addr)) && (code != 1);
                bit guard = (code == 0 || code == 3) && rd == 0 && !wel;
                if (hit && !guard) begin
                    m_mode = 2; e_oe = 1; e_act = 1; e_rd = rd[0];
                    e_sel = (code == 0) ? 3'b001 : (code == 2) ? 3'b010 : 3'b100;
                end else begin
                    m_mode = 4;
                    if (hit) e_rej++;
                end
            end else if (m_mode == 2) begin
                m_mode = 3; e_oe = 0;
            end
        end
    endtask

    task automatic step(input logic s, input logic d);
        logic os, ol;
        chk_en = 0;
        os = m_scl;
        ol = m_sda & ~e_oe;
        m_scl = s;
        m_sda = d;
        repeat (SETTLE) @(negedge clk);
        model(os, ol, s, d & ~e_oe);
        chk_en = 1;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic do_start;
        step(0, m_sda); step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    endtask

    task automatic do_stop;
        step(0, 0); step(1, 0); step(1, 1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            step(0, b[i]); step(1, b[i]); step(0, b[i]);
        end
    endtask

    task automatic send_addr(input logic [7:0] b, input logic want_ack,
                             input logic [2:0] want_sel, input string req);
        tag = req;
        do_start();
        send_bits(b, 8);
        step(0, 1);
        step(1, 1);
        check(req, int'(!sda_bus), int'(want_ack), "ack seen in ninth clock");
        step(0, 1);
        check(req, int'(target_sel), int'(want_sel), "target_sel");
        check(req, int'(txn_active), int'(want_ack), "txn_active");
        check("R6", int'(rd_flag), want_ack ? int'(b[0]) : 0, "rd_flag");
        check("R7", seen_rej, e_rej, "reject pulse count");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", int'({ack_drive_low, target_sel, rd_flag, txn_active, wr_reject}), 0, "outputs after reset");

        // R3 R5 R6: memory read
        send_addr(8'hA1, 1, 3'b001, "R3");
        do_stop();
        tag = "R2";
        check("R2", int'(txn_active), 0, "active after STOP");
        check("R2", int'(target_sel), 0, "select after STOP");

        // R7: control/status write ignores wel
        send_addr(8'hA4, 1, 3'b010, "R7");
        do_stop();
        // R7: potentiometer write refused with wel low
        send_addr(8'hA6, 0, 3'b000, "R7");
        do_stop();
        check("R7", seen_rej, 1, "one reject after refused pot write");
        wel = 1;
        send_addr(8'hA6, 1, 3'b100, "R5");
        do_stop();
        wel = 0;
        send_addr(8'hA0, 0, 3'b000, "R7");
        do_stop();
        check("R7", seen_rej, 2, "reject after refused memory write");

        // R3 wrong family, then R9 clocks ignored
        send_addr(8'hB1, 0, 3'b000, "R3");
        tag = "R9";
        send_bits(8'hA1, 8);
        step(0, 1); step(1, 1);
        check("R9", int'(!sda_bus), 0, "no ack while ignoring");
        step(0, 1);
        check("R9", int'(txn_active), 0, "still inactive while ignoring");
        do_stop();

        // R5 reserved code, both directions
        send_addr(8'hA2, 0, 3'b000, "R5");
        do_stop();
        send_addr(8'hA3, 0, 3'b000, "R5");
        do_stop();
        check("R5", seen_rej, 2, "reserved code raises no reject");

        // R4 strap match
        phys_addr = 1;
        send_addr(8'hA1, 0, 3'b000, "R4");
        do_stop();
        send_addr(8'hA9, 1, 3'b001, "R4");
        do_stop();
        phys_addr = 0;

        // R10 repeated START while selected
        send_addr(8'hA7, 1, 3'b100, "R10");
        send_addr(8'hA5, 1, 3'b010, "R10");
        check("R10", int'(rd_flag), 1, "read flag after restart");
        do_stop();

        // R2 STOP in the middle of the address byte, then R8 fresh count
        tag = "R2";
        do_start();
        send_bits(8'hA1, 4);
        do_stop();
        check("R2", int'(txn_active), 0, "idle after STOP mid-byte");
        send_addr(8'hA5, 1, 3'b010, "R8");
        check("R8", int'(ack_drive_low), 0, "ack released after ninth clock");
        do_stop();

        repeat (20) @(negedge clk);
        report();
    end
endmodule